// File: doc/BRIEF.md
# Multiplexed sampling step controller

This block paces one measurement step of a performance and power monitoring engine from a slow periodic tick. A step splits into two equal halves. A small pool of event counters is shared across the halves: during the first half the pool counts one group of event strobes, and during the second half it counts the other group. The total number of event lines is therefore twice the pool size. At each half boundary the pool's values are captured and the pool is cleared. At the end of the step, all per-event totals are published together on one flat output bus.

Each half is also cut into equal power slots. At the end of every slot one power reading is taken. This is the reading presented in that cycle if one is valid, and otherwise the most recent earlier reading. The readings of all slots of the step are averaged. The average and a one-cycle done pulse appear two clock cycles after the tick that closes the step. A sticky warning flag records any slot that closed without a fresh reading.

With the defaults (20 ticks per slot, 5 slots per half, six counters) a 1 kHz tick gives 20 ms slots, 100 ms halves, a 200 ms step, twelve events and ten power readings per step.

Top module: `mux_step_ctrl`

## Requirements
- R1: A slot lasts TICKS_PER_SLOT ticks, a half lasts SLOTS_PER_HALF slots and a step lasts two halves. `step_done` is high for exactly one clock cycle, two clock cycles after the cycle that carries the step's final tick.
- R2: `ctr_sel` is 0 during the first half and 1 during the second half. It changes only at a half boundary. Counter i counts `evt[i]` while `ctr_sel` is 0 and `evt[NCTR+i]` while `ctr_sel` is 1.
- R3: Strobes on the event lines of the group that is not selected have no effect on any total.
- R4: In the cycle whose tick ends a half, `ctr_en` is low. Strobes in that cycle are not counted. The pool is captured and cleared in that cycle. Strobes on ordinary slot-ending tick cycles are still counted.
- R5: Field k of `evt_totals` (bits k*CW to k*CW+CW-1) holds the count of `evt[k]` over the most recent complete step. All fields update together at the step's final tick.
- R6: A counter saturates at 2^CW-1 and does not wrap.
- R7: At each slot end the sampled power is `pwr_data` if `pwr_valid` is high in that cycle. Otherwise it is the last value seen with `pwr_valid` high, held across slots and steps. Before any valid reading it is 0.
- R8: `pwr_avg` equals the floor of the sum of the step's 2*SLOTS_PER_HALF samples divided by their count. It becomes valid together with `step_done`, and no precision is lost in the sum.
- R9: `pwr_warn` is set when a slot ends with no `pwr_valid` in any cycle of that slot. It stays set until reset.
- R10: After reset, `evt_totals` and `pwr_avg` are 0, `step_done` and `pwr_warn` are 0, `ctr_sel` is 0 and `ctr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse (1 kHz nominal) |
| evt | input | 2*NCTR | Event strobes, one count per high cycle |
| pwr_valid | input | 1 | Power reading present on `pwr_data` this cycle |
| pwr_data | input | PW | Power reading |
| ctr_sel | output | 1 | Event group currently routed to the counter pool |
| ctr_en | output | 1 | Counter pool enabled this cycle |
| evt_totals | output | 2*NCTR*CW | Per-event totals of the last step, field k for `evt[k]` |
| pwr_avg | output | PW | Mean power of the last step |
| step_done | output | 1 | One-cycle pulse when the step's results are ready |
| pwr_warn | output | 1 | Sticky flag for a slot that closed without a fresh reading |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that reset is held until the clock runs. They also assume that ticks stay far enough apart that a step's results are published before the next step's final tick. The stimulus raises `tick` on one cycle in four and never on two cycles in a row. It delivers power readings at most once per few cycles, each with `pwr_valid` high for one cycle. The event strobes are driven on every cycle, including the boundary cycles, so that the dropped-strobe behaviour is exercised and not avoided.

// File: rtl/mstep_pkg.sv
package mstep_pkg;
  typedef enum logic {
    SET_A = 1'b0,
    SET_B = 1'b1
  } evset_e;
endpackage

// File: rtl/mstep_timer.sv
module mstep_timer
  import mstep_pkg::*;
#(
  parameter int TICKS_PER_SLOT = 20,
  parameter int SLOTS_PER_HALF = 5
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  output logic   slot_end,
  output logic   half_end,
  output logic   step_end,
  output evset_e cur_set
);
  localparam int TW = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;
  localparam int SW = (SLOTS_PER_HALF > 1) ? $clog2(SLOTS_PER_HALF) : 1;

  logic [TW-1:0] tick_q;
  logic [SW-1:0] slot_q;
  evset_e        set_q;

  assign slot_end = tick && (tick_q == TW'(TICKS_PER_SLOT - 1));
  assign half_end = slot_end && (slot_q == SW'(SLOTS_PER_HALF - 1));
  assign step_end = half_end && (set_q == SET_B);
  assign cur_set  = set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      slot_q <= '0;
      set_q  <= SET_A;
    end else if (tick) begin
      tick_q <= slot_end ? '0 : tick_q + TW'(1);
      if (slot_end) begin
        slot_q <= half_end ? '0 : slot_q + SW'(1);
      end
      if (half_end) begin
        set_q <= (set_q == SET_A) ? SET_B : SET_A;
      end
    end
  end
endmodule

// File: rtl/mstep_evbank.sv
module mstep_evbank
  import mstep_pkg::*;
#(
  parameter int NCTR = 6,
  parameter int CW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*NCTR-1:0]  evt,
  input  evset_e             cur_set,
  input  logic               half_end,
  input  logic               step_end,
  output logic               ctr_en,
  output logic [2*NCTR*CW-1:0] totals
);
  // Saturating increment: holds at all-ones.
  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v, input logic hit);
    if (hit && (v != {CW{1'b1}})) return v + CW'(1);
    return v;
  endfunction

  assign ctr_en = !half_end;

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    logic [CW-1:0] cnt;
    logic [CW-1:0] stage;
    logic [CW-1:0] tot_a;
    logic [CW-1:0] tot_b;
    logic          src;

    assign src = (cur_set == SET_A) ? evt[i] : evt[NCTR+i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt   <= '0;
        stage <= '0;
        tot_a <= '0;
        tot_b <= '0;
      end else begin
        if (half_end) cnt <= '0;
        else          cnt <= sat_inc(cnt, src && ctr_en);
        if (half_end && (cur_set == SET_A)) stage <= cnt;
        if (step_end) begin
          tot_a <= stage;
          tot_b <= cnt;
        end
      end
    end

    assign totals[i*CW +: CW]        = tot_a;
    assign totals[(NCTR+i)*CW +: CW] = tot_b;
  end
endmodule

// File: rtl/mstep_pwravg.sv
module mstep_pwravg #(
  parameter int PW    = 16,
  parameter int NSAMP = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_end,
  input  logic          step_end,
  input  logic          pwr_valid,
  input  logic [PW-1:0] pwr_data,
  output logic [PW-1:0] avg,
  output logic          done,
  output logic          warn
);
  localparam int AW = PW + $clog2(NSAMP + 1);

  function automatic logic [PW-1:0] mean(input logic [AW-1:0] s);
    return PW'(s / AW'(NSAMP));
  endfunction

  logic [PW-1:0] held;
  logic [PW-1:0] sample;
  logic          got;
  logic [AW-1:0] acc;
  logic [AW-1:0] fin;
  logic          pend;

  assign sample = pwr_valid ? pwr_data : held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      got  <= 1'b0;
      acc  <= '0;
      fin  <= '0;
      pend <= 1'b0;
      done <= 1'b0;
      avg  <= '0;
      warn <= 1'b0;
    end else begin
      if (pwr_valid) held <= pwr_data;
      if (slot_end)       got <= 1'b0;
      else if (pwr_valid) got <= 1'b1;
      if (slot_end && !pwr_valid && !got) warn <= 1'b1;
      if (step_end)      acc <= '0;
      else if (slot_end) acc <= acc + AW'(sample);
      if (step_end) fin <= acc + AW'(sample);
      pend <= step_end;
      done <= pend;
      if (pend) avg <= mean(fin);
    end
  end
endmodule

// File: rtl/mux_step_ctrl.sv
module mux_step_ctrl
  import mstep_pkg::*;
#(
  parameter int TICKS_PER_SLOT = 20,
  parameter int SLOTS_PER_HALF = 5,
  parameter int NCTR           = 6,
  parameter int CW             = 32,
  parameter int PW             = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [2*NCTR-1:0]    evt,
  input  logic                 pwr_valid,
  input  logic [PW-1:0]        pwr_data,
  output logic                 ctr_sel,
  output logic                 ctr_en,
  output logic [2*NCTR*CW-1:0] evt_totals,
  output logic [PW-1:0]        pwr_avg,
  output logic                 step_done,
  output logic                 pwr_warn
);
  localparam int NSAMP = 2 * SLOTS_PER_HALF;

  logic   slot_end;
  logic   half_end;
  logic   step_end;
  evset_e cur_set;

  mstep_timer #(
    .TICKS_PER_SLOT(TICKS_PER_SLOT),
    .SLOTS_PER_HALF(SLOTS_PER_HALF)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .slot_end(slot_end), .half_end(half_end), .step_end(step_end),
    .cur_set(cur_set)
  );

  mstep_evbank #(.NCTR(NCTR), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt), .cur_set(cur_set),
    .half_end(half_end), .step_end(step_end),
    .ctr_en(ctr_en), .totals(evt_totals)
  );

  mstep_pwravg #(.PW(PW), .NSAMP(NSAMP)) u_pwr (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .step_end(step_end),
    .pwr_valid(pwr_valid), .pwr_data(pwr_data),
    .avg(pwr_avg), .done(step_done), .warn(pwr_warn)
  );

  assign ctr_sel = (cur_set == SET_B);
endmodule

// File: rtl/mstep_chk.sv
module mstep_chk (
  input logic clk,
  input logic rst_n,
  input logic half_end,
  input logic step_end,
  input logic ctr_sel,
  input logic ctr_en,
  input logic step_done,
  input logic pwr_warn
);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !step_done);
  // R1
  done_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> $past(step_end, 2));
  // R1
  step_in_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |-> (half_end && ctr_sel));
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_end |=> $stable(ctr_sel));
  // R2
  sel_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_end |=> (ctr_sel != $past(ctr_sel)));
  // R4
  en_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_end |-> !ctr_en);
  // R9
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_warn |=> pwr_warn);
endmodule

bind mux_step_ctrl mstep_chk u_chk (
  .clk(clk), .rst_n(rst_n), .half_end(half_end), .step_end(step_end),
  .ctr_sel(ctr_sel), .ctr_en(ctr_en), .step_done(step_done),
  .pwr_warn(pwr_warn)
);

// File: tb/sim_mux_step_ctrl.sv
module sim_mux_step_ctrl;
  localparam int TPS = 20, SPH = 5, NC = 6, CW = 8, PW = 12;
  localparam int NE = 2 * NC, TPSTEP = 2 * SPH * TPS, NSTEPS = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pwr_valid = 1'b0;
  logic [NE-1:0] evt = '0;
  logic [PW-1:0] pwr_data = '0;
  logic ctr_sel, ctr_en, step_done, pwr_warn;
  logic [NE*CW-1:0] evt_totals;
  logic [PW-1:0] pwr_avg;

  always #10 clk = ~clk;

  mux_step_ctrl #(.TICKS_PER_SLOT(TPS), .SLOTS_PER_HALF(SPH), .NCTR(NC),
                  .CW(CW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt),
    .pwr_valid(pwr_valid), .pwr_data(pwr_data), .ctr_sel(ctr_sel),
    .ctr_en(ctr_en), .evt_totals(evt_totals), .pwr_avg(pwr_avg),
    .step_done(step_done), .pwr_warn(pwr_warn));

  int nvec = 0, nfail = 0, ndone = 0, cyc = 0;
  bit finished = 1'b0;
  int q_cnt[$];
  int q_avg[$];
  int q_when[$];
  bit q_warn[$];
  int last_pwr = 0;
  bit warn_exp = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int expv);
    nvec++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit pat(input int mode, input int seed, input int g, input int e);
    if (mode == 2) return (e == 0 || e == 6) ? 1'b1 : 1'b0;
    if (mode == 4) return ((e == 2 && (g == 3 || g == 399 || g == 799)) ||
                           (e == 8 && (g == 403 || g == 799))) ? 1'b1 : 1'b0;
    return ((g * (e + 2) + seed * 7 + e) % (e + 3)) == 0;
  endfunction

  // Driver: runs one step and pushes the expected results.
  task automatic run_step(input int mode, input int seed);
    int ex[NE];
    int acc = 0;
    bit got = 1'b0;
    for (int e = 0; e < NE; e++) ex[e] = 0;
    for (int t = 0; t < TPSTEP; t++) begin
      for (int p = 0; p < 4; p++) begin
        int g = t * 4 + p;
        int slot = t / TPS;
        int ts = t % TPS;
        bit is_tick = (p == 3);
        bit bound = is_tick && (t == TPSTEP / 2 - 1 || t == TPSTEP - 1);
        int hs = (t < TPSTEP / 2) ? 0 : 1;
        bit pv = 1'b0;
        int pd = 0;
        logic [NE-1:0] ev;
        @(negedge clk);
        if (t == 50 && p == 0) chk("R2 sel first half", int'(ctr_sel), 0);
        if (t == 150 && p == 0) chk("R2 sel second half", int'(ctr_sel), 1);
        if (mode == 3) begin
          pv = (ts == 5 && p == 1); pd = 4095;
        end else if (mode == 1 && (slot % 2) == 1) begin
          pv = (ts == TPS - 1 && p == 3); pd = (seed * 131 + slot * 53 + 7) % 4096;
        end else if (!(mode == 2 && slot == 3)) begin
          pv = (ts == 7 && p == 1); pd = (seed * 311 + slot * 97 + 13) % 4096;
        end
        for (int e = 0; e < NE; e++) begin
          ev[e] = pat(mode, seed, g, e);
          if (ev[e] && !bound && (e / NC) == hs && ex[e] < 255) ex[e]++;
        end
        if (pv) begin last_pwr = pd; got = 1'b1; end
        if (is_tick && ts == TPS - 1) begin
          acc += last_pwr;
          if (!got) warn_exp = 1'b1;
          got = 1'b0;
        end
        if (is_tick && t == TPSTEP - 1) q_when.push_back(cyc + 2);
        tick = is_tick; evt = ev; pwr_valid = pv; pwr_data = PW'(pd);
      end
    end
    for (int e = 0; e < NE; e++) q_cnt.push_back(ex[e]);
    q_avg.push_back(acc / (2 * SPH));
    q_warn.push_back(warn_exp);
  endtask

  // Monitor: pops expected items on every done pulse.
  always @(negedge clk) begin
    if (rst_n && step_done) begin
      ndone++;
      if (q_avg.size() == 0) chk("R1 unexpected done", 1, 0);
      else begin
        chk("R1 done timing", cyc, q_when.pop_front());
        for (int e = 0; e < NE; e++)
          chk($sformatf("R5/R3/R4/R6 total %0d", e), int'(evt_totals[e*CW +: CW]),
              q_cnt.pop_front());
        chk("R8/R7 average", int'(pwr_avg), q_avg.pop_front());
        chk("R9 warn", int'(pwr_warn), int'(q_warn.pop_front()));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 totals", int'(|evt_totals), 0);
    chk("R10 avg", int'(pwr_avg), 0);
    chk("R10 done", int'(step_done), 0);
    chk("R10 warn", int'(pwr_warn), 0);
    chk("R10 sel", int'(ctr_sel), 0);
    chk("R10 en", int'(ctr_en), 1);
    run_step(0, 0);  // R1 R2 R3 R5 R7 R8: patterned events
    run_step(1, 1);  // R7: reading on the slot-ending cycle
    run_step(4, 0);  // R4: strobes on boundary ticks
    run_step(2, 0);  // R6 saturation, R9 missing slot
    run_step(3, 2);  // R8 full-scale average
    @(negedge clk); tick = 1'b0; evt = '0; pwr_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 step count", ndone, NSTEPS);
    chk("R1 queue drained", q_avg.size(), 0);
    finish_run();
  end
endmodule